// File: doc/BRIEF.md
# Packet Command Programmed-I/O Burst Sequencer

This block is the device side of a storage packet command that returns its data by programmed I/O. The host first writes a 16-bit byte-count limit into two byte registers. It then issues the packet opcode on the command register. The block reports busy for a fixed number of cycles. It then requests a 12-byte command packet, which the host delivers as six 16-bit writes to the data port. The block interprets only a block-read command, taking from the packet a starting block address and a block count.

The requested data, `count * BLK_BYTES` bytes, is then returned through the data port in bursts. Each burst is no larger than the programmed limit. Each burst is announced by an interrupt and a data-request status, and the host reads the burst's words one by one. After the last word the block raises a final completion interrupt and returns to ready. The bytes come from an internal pattern source addressed by absolute byte position. Reading the status register acknowledges a pending interrupt.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40, irq_o is low, and both limit registers (addresses 4 and 5) read 0.
- R2: Status bits are BSY=7, DRDY=6, DF=5, DRQ=3 and ERR=0. Writing 0xA0 to address 7 while ready starts a command: status reads 0xC0 for CMD_DELAY cycles, then 0x48 while the packet is awaited. Other opcodes, and commands issued while not ready, are ignored.
- R3: The packet is six little-endian words, so byte 2k is word k bits 7:0. Byte 0 is the opcode. Bytes 2..5 hold the block address, most significant byte first. Bytes 7..8 hold the block count, most significant byte first. Any opcode other than 0x28 aborts the command with an interrupt, and status then reads 0x41.
- R4: Address 4 holds the low byte of the limit and address 5 the high byte; both read back. The limit is captured when the command starts, so later writes to it do not change the bursts of that command.
- R5: The effective burst size is the limit with bit 0 cleared, or 2 when that result is 0. Every burst is this size except the last, which carries the remainder.
- R6: Before each burst irq_o rises and status reads 0x48. The host then reads exactly the burst's byte count divided by two words from address 0. Between bursts status reads 0xC0 for one cycle.
- R7: The word read at byte offset a from the start of the command's data is {P(b+1), P(b)}, where b = lba*BLK_BYTES + a and P(x) is the XOR of the four bytes of x.
- R8: After the final word, a completion interrupt is raised and status reads 0x40.
- R9: A status read clears irq_o on the next edge. If an interrupt is raised in the same cycle as a status read, the interrupt stays set.
- R10: A block count of zero completes with an interrupt and status 0x40, with no data phase.
- R11: Data-port reads outside a data phase return 0 and have no effect. Data-port writes outside the packet phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (read side effects) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The block has two functions that can fall on the same edge: an interrupt being raised and an interrupt being acknowledged by a status read. To provoke this, the bench issues a status read in the single busy cycle that follows the last word of a non-final burst. That read must return 0xC0. irq_o must be high after the edge, because the raise takes priority over the acknowledge, and a second status read must then return 0x48 and clear irq_o. Sweeps over limits, including odd values, zero and near-maximum values, and over block counts from zero to three compute every burst length and data word arithmetically.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CDLY, ST_PKT, ST_LOAD, ST_PLAN, ST_XFER
  } seq_state_e;

  localparam int unsigned PKT_WORDS = 6;

  localparam logic [7:0] STS_BSY  = 8'h80;
  localparam logic [7:0] STS_DRDY = 8'h40;
  localparam logic [7:0] STS_DF   = 8'h20;
  localparam logic [7:0] STS_DRQ  = 8'h08;
  localparam logic [7:0] STS_ERR  = 8'h01;

  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam logic [7:0] OP_RD10   = 8'h28;

  localparam logic [2:0] REG_DATA   = 3'd0;
  localparam logic [2:0] REG_LIM_LO = 3'd4;
  localparam logic [2:0] REG_LIM_HI = 3'd5;
  localparam logic [2:0] REG_CMD    = 3'd7;
endpackage

// File: rtl/atapi_pkt_collect.sv
module atapi_pkt_collect
  import atapi_pio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  output logic        last_o,
  output logic [7:0]  opcode_o,
  output logic [31:0] lba_o,
  output logic [15:0] count_o
);
  localparam int unsigned CNT_W = $clog2(PKT_WORDS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = wr_i && (cnt_q == CNT_W'(PKT_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      opcode_o <= '0;
      lba_o    <= '0;
      count_o  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= cnt_q + 1'b1;
      // little-endian words carrying big-endian fields
      case (cnt_q)
        CNT_W'(0): opcode_o       <= wdata_i[7:0];
        CNT_W'(1): lba_o[31:16]   <= {wdata_i[7:0], wdata_i[15:8]};
        CNT_W'(2): lba_o[15:0]    <= {wdata_i[7:0], wdata_i[15:8]};
        CNT_W'(3): count_o[15:8]  <= wdata_i[15:8];
        CNT_W'(4): count_o[7:0]   <= wdata_i[7:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/atapi_burst_plan.sv
module atapi_burst_plan #(
  parameter int unsigned CW = 32
) (
  input  logic [15:0]   limit_i,
  input  logic [CW-1:0] remain_i,
  output logic [15:0]   words_o
);
  logic [15:0] eff;
  logic [15:0] bytes;

  always_comb begin
    eff = limit_i & 16'hFFFE;
    if (eff == 16'd0) eff = 16'd2;
    if (remain_i < CW'(eff)) bytes = remain_i[15:0];
    else                     bytes = eff;
    words_o = bytes >> 1;
  end
endmodule

// File: rtl/atapi_pattern_src.sv
module atapi_pattern_src #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  output logic [15:0]   word_o
);
  localparam int unsigned NB = AW / 8;

  function automatic logic [7:0] fold(input logic [AW-1:0] a);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < NB; i++) r ^= a[8*i +: 8];
    return r;
  endfunction

  assign word_o = {fold(addr_i | AW'(1)), fold(addr_i & ~AW'(1))};
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
  import atapi_pio_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 2048,
  parameter int unsigned CMD_DELAY = 4,
  parameter int unsigned CW        = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o
);
  localparam int unsigned BLK_SHIFT = $clog2(BLK_BYTES);
  localparam int unsigned DLY_W     = $clog2(CMD_DELAY + 1);

  seq_state_e     state_q, state_d;
  logic [15:0]    lim_reg_q, lim_q;
  logic [DLY_W-1:0] dly_q;
  logic [CW-1:0]  remain_q, addr_q;
  logic [15:0]    words_q, plan_words, pat_word;
  logic           irq_q, err_q, irq_set;
  logic [7:0]     status;

  logic        pkt_last;
  logic [7:0]  pkt_op;
  logic [31:0] pkt_lba;
  logic [15:0] pkt_cnt;

  wire wr_cmd  = we_i && (addr_i == REG_CMD);
  wire data_wr = we_i && (addr_i == REG_DATA);
  wire data_rd = re_i && (addr_i == REG_DATA) && (state_q == ST_XFER);
  wire stat_rd = re_i && (addr_i == REG_CMD);
  wire start   = (state_q == ST_IDLE) && wr_cmd && (wdata_i[7:0] == OP_PACKET);
  wire bad_op  = (pkt_op != OP_RD10);

  atapi_pkt_collect u_pkt (
    .clk_i, .rst_ni,
    .clr_i   (start),
    .wr_i    (data_wr && state_q == ST_PKT),
    .wdata_i,
    .last_o  (pkt_last),
    .opcode_o(pkt_op),
    .lba_o   (pkt_lba),
    .count_o (pkt_cnt)
  );

  atapi_burst_plan #(.CW(CW)) u_plan (
    .limit_i (lim_q),
    .remain_i(remain_q),
    .words_o (plan_words)
  );

  atapi_pattern_src #(.AW(CW)) u_pat (
    .addr_i(addr_q),
    .word_o(pat_word)
  );

  always_comb begin
    state_d = state_q;
    irq_set = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_CDLY;
      ST_CDLY: if (dly_q == DLY_W'(CMD_DELAY - 1)) state_d = ST_PKT;
      ST_PKT:  if (pkt_last) state_d = ST_LOAD;
      ST_LOAD: begin
        if (bad_op || pkt_cnt == 16'd0) begin
          state_d = ST_IDLE;
          irq_set = 1'b1;
        end else begin
          state_d = ST_PLAN;
        end
      end
      ST_PLAN: begin
        state_d = ST_XFER;
        irq_set = 1'b1;
      end
      ST_XFER: begin
        if (data_rd && words_q == 16'd1) begin
          if (remain_q == CW'(2)) begin
            state_d = ST_IDLE;
            irq_set = 1'b1;
          end else begin
            state_d = ST_PLAN;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lim_reg_q <= '0;
      lim_q     <= '0;
      dly_q     <= '0;
      remain_q  <= '0;
      addr_q    <= '0;
      words_q   <= '0;
      irq_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (we_i && addr_i == REG_LIM_LO) lim_reg_q[7:0]  <= wdata_i[7:0];
      if (we_i && addr_i == REG_LIM_HI) lim_reg_q[15:8] <= wdata_i[7:0];
      // raise wins over acknowledge
      if (irq_set)      irq_q <= 1'b1;
      else if (stat_rd) irq_q <= 1'b0;
      if (start) begin
        err_q <= 1'b0;
        lim_q <= lim_reg_q;
        dly_q <= '0;
      end
      if (state_q == ST_CDLY) dly_q <= dly_q + 1'b1;
      if (state_q == ST_LOAD) begin
        err_q    <= bad_op;
        remain_q <= CW'(pkt_cnt) << BLK_SHIFT;
        addr_q   <= CW'(pkt_lba) << BLK_SHIFT;
      end
      if (state_q == ST_PLAN) words_q <= plan_words;
      if (data_rd) begin
        words_q  <= words_q - 1'b1;
        remain_q <= remain_q - CW'(2);
        addr_q   <= addr_q + CW'(2);
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:                   status = STS_DRDY | (err_q ? STS_ERR : 8'h00);
      ST_CDLY, ST_LOAD, ST_PLAN: status = STS_BSY | STS_DRDY;
      ST_PKT, ST_XFER:           status = STS_DRDY | STS_DRQ;
      default:                   status = STS_DRDY;
    endcase
  end

  always_comb begin
    unique case (addr_i)
      REG_DATA:   rdata_o = (state_q == ST_XFER) ? pat_word : 16'h0000;
      REG_LIM_LO: rdata_o = {8'h00, lim_reg_q[7:0]};
      REG_LIM_HI: rdata_o = {8'h00, lim_reg_q[15:8]};
      REG_CMD:    rdata_o = {8'h00, status};
      default:    rdata_o = 16'h0000;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk
  import atapi_pio_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        re_i,
  input logic [2:0]  addr_i,
  input logic        irq_o,
  input logic [7:0]  status_i,
  input seq_state_e  state_i,
  input logic [15:0] words_i
);
  // R6
  drq_bsy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((status_i & STS_BSY) != 0 && (status_i & STS_DRQ) != 0));

  // R9
  rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == REG_CMD && (status_i & STS_BSY) == 0) |=> !irq_o);

  // R8
  irq_rise_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (status_i & STS_BSY) == 0);

  // R6
  xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_XFER && !(re_i && addr_i == REG_DATA))
      |=> (state_i == ST_XFER && $stable(words_i)));

  // R5
  words_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_XFER |-> words_i != 16'd0);
endmodule

bind atapi_pio_seq atapi_pio_seq_chk u_chk (
  .clk_i, .rst_ni, .re_i, .addr_i, .irq_o,
  .status_i(status),
  .state_i (state_q),
  .words_i (words_q)
);

// File: tb/atapi_pio_seq_bench.sv
module atapi_pio_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atapi_pio_seq #(.BLK_BYTES(BLK), .CMD_DELAY(3), .CW(32)) u_atapi_pio_seq (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 40 && !irq; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input logic [31:0] x);
    return x[7:0] ^ x[15:8] ^ x[23:16] ^ x[31:24];
  endfunction

  task automatic start_cmd(input logic [15:0] lim);
    logic [15:0] s;
    wr(3'd4, {8'h00, lim[7:0]});
    wr(3'd5, {8'h00, lim[15:8]});
    wr(3'd7, 16'h00A0);
    rd(3'd7, s);
    chk("R2 busy after command", s, 16'h00C0);
    for (int i = 0; i < 10 && s != 16'h0048; i++) rd(3'd7, s);
    chk("R2 packet request", s, 16'h0048);
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] cnt);
    wr(3'd0, {8'h00, op});
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {cnt[15:8], 8'h00});
    wr(3'd0, {8'h00, cnt[7:0]});
    wr(3'd0, 16'h0000);
  endtask

  task automatic run(input logic [15:0] lim, input logic [31:0] lba, input int cnt,
                     input bit conc, input bit poke);
    logic [15:0] s, d;
    int total, eff, off, n;
    bit conc_done, poke_done;
    conc_done = 0; poke_done = 0;
    start_cmd(lim);
    send_pkt(8'h28, lba, 16'(cnt));
    total = cnt * BLK;
    eff = lim & 16'hFFFE;
    if (eff == 0) eff = 2;
    off = 0;
    if (total == 0) begin
      wait_irq();
      chk("R10 zero-count irq", 16'(irq), 16'h1);
      rd(3'd7, s);
      chk("R10 zero-count status", s, 16'h0040);
      chk("R9 irq cleared", 16'(irq), 16'h0);
      return;
    end
    while (off < total) begin
      wait_irq();
      chk("R6 burst irq", 16'(irq), 16'h1);
      rd(3'd7, s);
      chk("R6 burst status", s, 16'h0048);
      chk("R9 irq cleared by status", 16'(irq), 16'h0);
      n = ((total - off) < eff ? (total - off) : eff) / 2;
      for (int i = 0; i < n; i++) begin
        rd(3'd0, d);
        chk("R7 data word", d, {pat(lba * BLK + off + 1), pat(lba * BLK + off)});
        off += 2;
        if (poke && !poke_done) begin
          poke_done = 1;
          wr(3'd4, 16'h0004);
          wr(3'd5, 16'h0000);
          rd(3'd4, s);
          chk("R4 limit readback", s, 16'h0004);
        end
      end
      if (conc && !conc_done && off < total) begin
        conc_done = 1;
        rd(3'd7, s);
        chk("R9 status between bursts", s, 16'h00C0);
        chk("R9 raise wins over acknowledge", 16'(irq), 16'h1);
      end
    end
    wait_irq();
    chk("R8 completion irq", 16'(irq), 16'h1);
    rd(3'd7, s);
    chk("R8 completion status", s, 16'h0040);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] s;
    int lims[12] = '{0, 1, 2, 3, 6, 7, 31, 32, 33, 64, 100, 16'hFFFE};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(3'd7, s); chk("R1 reset status", s, 16'h0040);
    chk("R1 reset irq", 16'(irq), 16'h0);
    rd(3'd4, s); chk("R1 reset limit low", s, 16'h0000);
    rd(3'd5, s); chk("R1 reset limit high", s, 16'h0000);

    // R11 idle data port
    rd(3'd0, s); chk("R11 idle data read", s, 16'h0000);
    wr(3'd0, 16'h1234);
    rd(3'd7, s); chk("R11 idle data write ignored", s, 16'h0040);

    // R2 foreign opcode ignored
    wr(3'd7, 16'h00EC);
    rd(3'd7, s); chk("R2 foreign opcode ignored", s, 16'h0040);

    // R3 bad packet opcode; R2 command during packet phase ignored
    start_cmd(16'd8);
    wr(3'd7, 16'h00A0);
    rd(3'd7, s); chk("R2 command while active ignored", s, 16'h0048);
    send_pkt(8'h12, 32'd0, 16'd1);
    wait_irq();
    chk("R3 abort irq", 16'(irq), 16'h1);
    rd(3'd7, s); chk("R3 abort status", s, 16'h0041);
    rd(3'd0, s); chk("R11 data read after abort", s, 16'h0000);

    // R4 limit captured at command
    run(16'd10, 32'd3, 2, 1'b0, 1'b1);
    // R9 raise and acknowledge in the same cycle
    run(16'd8, 32'd9, 1, 1'b1, 1'b0);

    // R5 sweep of limits and counts
    for (int i = 0; i < 12; i++)
      for (int c = 0; c < 4; c++)
        run(16'(lims[i]), 32'(i * 37 + c * 4660), c, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule